// File: doc/BRIEF.md
# Bidirectional Open-Drain Bus Repeater

This block joins two open-drain two-wire bus segments, called side A and side B, on both the data line (SDA) and the clock line (SCL). When a device outside the block pulls a line low on one side, the block pulls the matching line low on the other side. When that device lets go, the block lets go too. Each pin is modelled as a sampled input level plus a pull-low enable. A pull-low enable of 1 drives the line low. A released line is taken high by external pull-ups.

Inside, each line has two opposite one-way paths and a small ownership machine with four states: idle, A-owns, B-owns and hold-off. While B owns a line, the block is itself pulling side A low. That low on side A is never sent back to side B, so the bus cannot latch itself low.

After the owning side releases, the line waits in hold-off for a programmable number of cycles before it returns to idle. This gives the released line time to rise. A parameter can make SCL one-way, from A to B only. A global enable releases every output at once.

Top module: `od_bus_repeater`

## Requirements
- R1: After reset, all four pull-low outputs are 0.
- R2: Side A goes low while a line is idle. The pull on side B of that line becomes 1 in the third rising clock edge after the input change: two synchronizer edges plus one state edge.
- R3: Side B goes low while a bidirectional line is idle and side A is high. The pull on side A becomes 1 with the same three-edge latency.
- R4: A low on side A caused by the block's own pull-low is not forwarded to side B. After side B releases, both pulls on that line return to 0 and stay 0 (no stuck-low lockup), provided `holdoff_cycles` is at least 2.
- R5: If both sides of an idle line are seen low in the same cycle, side A wins: the pull on side B becomes 1 and the pull on side A stays 0.
- R6: When the owning side is seen released, both pulls of that line drop to 0. The line then ignores both inputs for `holdoff_cycles`+1 edges and only then becomes idle. A low on side B during that time takes effect on the edge after the line becomes idle.
- R7: With `SCL_ONEWAY`=1, `a_scl_pull` is never 1 and a low on side-B SCL has no effect. Side-A SCL lows are still forwarded to side B.
- R8: While `enable` is 0, all pulls are 0 at once and every line returns to idle on the next edge. After `enable` returns to 1, ownership starts again from idle.
- R9: Ownership is taken only from idle. While B owns a line, an external low on side A neither pulls side B nor releases side A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global enable; when 0, all pulls are released |
| holdoff_cycles | input | HOLD_W | Hold-off length after a release |
| a_sda_in | input | 1 | Side A SDA level |
| a_scl_in | input | 1 | Side A SCL level |
| b_sda_in | input | 1 | Side B SDA level |
| b_scl_in | input | 1 | Side B SCL level |
| a_sda_pull | output | 1 | 1 pulls side A SDA low |
| a_scl_pull | output | 1 | 1 pulls side A SCL low |
| b_sda_pull | output | 1 | 1 pulls side B SDA low |
| b_scl_pull | output | 1 | 1 pulls side B SCL low |

## Verification
The bench models each wire as the AND of an external driver and the block's own pull, so the block sees its own lows fed back. Directed cases each target one behaviour:
- A single-side low on A, and then on B, shows the latency in each direction.
- Simultaneous lows on both sides show the arbitration rule.
- A side-A low injected while B owns the line shows that ownership does not change hands.
- A B-side low timed into the hold-off window tells hold-off apart from an immediate return to idle.

A random phase then toggles the external drivers, the hold-off length and the enable. A second instance built for one-way SCL receives the same stimulus.

// File: rtl/odr_pkg.sv
package odr_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2,
    OWN_HOLD = 2'd3
  } own_t;

  // hold-off ends when the counter has run down to zero
  function automatic logic hold_expired(input logic [15:0] cnt);
    return (cnt == 16'd0);
  endfunction

endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/odr_line_ctrl.sv
module odr_line_ctrl
  import odr_pkg::*;
#(
  parameter bit BIDIR  = 1'b1,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [HOLD_W-1:0] holdoff,
  input  logic              a_lvl,
  input  logic              b_lvl,
  output logic              pull_a,
  output logic              pull_b
);
  own_t              state, state_nx;
  logic [HOLD_W-1:0] cnt, cnt_nx;

  // named internal events
  logic a_lo, b_lo, a_take, b_take, owner_gone, hold_end;

  assign a_lo       = !a_lvl;
  assign b_lo       = !b_lvl;
  assign a_take     = (state == OWN_IDLE) && a_lo;
  assign b_take     = BIDIR && (state == OWN_IDLE) && !a_lo && b_lo;
  assign owner_gone = ((state == OWN_A) && !a_lo) || ((state == OWN_B) && !b_lo);
  assign hold_end   = (state == OWN_HOLD) && hold_expired(16'(cnt));

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    if (a_take)          state_nx = OWN_A;
    else if (b_take)     state_nx = OWN_B;
    else if (owner_gone) begin
      state_nx = OWN_HOLD;
      cnt_nx   = holdoff;
    end else if (hold_end) state_nx = OWN_IDLE;
    else if (state == OWN_HOLD) cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state <= OWN_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  assign pull_b = enable && (state == OWN_A);
  assign pull_a = enable && (state == OWN_B);

  // R2
  a_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && a_take) |=> (pull_b || !enable));

  // R9
  b_hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (state == OWN_B && b_lo) |=> (state == OWN_B));

  // R6
  hold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (state == OWN_HOLD && cnt != '0) |=> (state == OWN_HOLD && !pull_a && !pull_b));

  // R8
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == OWN_IDLE));

  generate
    if (!BIDIR) begin : g_oneway_chk
      // R7
      oneway_no_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OWN_IDLE && !a_lo) |=> (state == OWN_IDLE));
    end
  endgenerate
endmodule

// File: rtl/od_bus_repeater.sv
module od_bus_repeater #(
  parameter int HOLD_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit SCL_ONEWAY  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [HOLD_W-1:0] holdoff_cycles,
  input  logic              a_sda_in,
  input  logic              a_scl_in,
  input  logic              b_sda_in,
  input  logic              b_scl_in,
  output logic              a_sda_pull,
  output logic              a_scl_pull,
  output logic              b_sda_pull,
  output logic              b_scl_pull
);
  localparam int NPIN = 4;
  localparam int NLINE = 2;

  logic [NPIN-1:0]  raw_lvl, syn_lvl;
  logic [NLINE-1:0] pa, pb;

  // bit order: {b_scl, b_sda, a_scl, a_sda}
  assign raw_lvl = {b_scl_in, b_sda_in, a_scl_in, a_sda_in};

  odr_sync #(.STAGES(SYNC_STAGES), .W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lvl), .q(syn_lvl)
  );

  generate
    for (genvar l = 0; l < NLINE; l++) begin : g_line
      localparam bit LINE_BIDIR = (l == 0) ? 1'b1 : !SCL_ONEWAY;
      odr_line_ctrl #(.BIDIR(LINE_BIDIR), .HOLD_W(HOLD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .holdoff(holdoff_cycles),
        .a_lvl(syn_lvl[l]), .b_lvl(syn_lvl[l+2]),
        .pull_a(pa[l]), .pull_b(pb[l])
      );
    end
  endgenerate

  assign a_sda_pull = pa[0];
  assign a_scl_pull = pa[1];
  assign b_sda_pull = pb[0];
  assign b_scl_pull = pb[1];

  generate
    if (SCL_ONEWAY) begin : g_ow_top
      // R7
      oneway_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_scl_pull);
    end
  endgenerate
endmodule

// File: tb/tb_od_bus_repeater.sv
module tb_od_bus_repeater;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [3:0] holdoff = 4'd3;
  logic [1:0] ext_a = '0, ext_b = '0;   // 1 = external device pulls low, [0]=SDA [1]=SCL
  int checks = 0, errors = 0;

  always #5 clk = !clk;

  // pulls indexed k = inst*2 + line
  logic [3:0] pa, pb;
  logic [3:0] a_pin, b_pin;
  for (genvar k = 0; k < 4; k++) begin : g_wire
    assign a_pin[k] = !(ext_a[k%2] || pa[k]);
    assign b_pin[k] = !(ext_b[k%2] || pb[k]);
  end

  od_bus_repeater #(.SCL_ONEWAY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .holdoff_cycles(holdoff),
    .a_sda_in(a_pin[0]), .a_scl_in(a_pin[1]), .b_sda_in(b_pin[0]), .b_scl_in(b_pin[1]),
    .a_sda_pull(pa[0]), .a_scl_pull(pa[1]), .b_sda_pull(pb[0]), .b_scl_pull(pb[1]));

  od_bus_repeater #(.SCL_ONEWAY(1'b1)) dut_ow (
    .clk(clk), .rst_n(rst_n), .enable(enable), .holdoff_cycles(holdoff),
    .a_sda_in(a_pin[2]), .a_scl_in(a_pin[3]), .b_sda_in(b_pin[2]), .b_scl_in(b_pin[3]),
    .a_sda_pull(pa[2]), .a_scl_pull(pa[3]), .b_sda_pull(pb[2]), .b_scl_pull(pb[3]));

  // reference model from the requirements: 0 idle, 1 A owns, 2 B owns, 3 hold-off
  logic [3:0] sa1, sa2, sb1, sb2;
  int m_st [4];
  int m_cnt [4];

  function automatic bit line_bidir(input int k);
    return !(k == 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      sa1 <= '1; sa2 <= '1; sb1 <= '1; sb2 <= '1;
      for (int k = 0; k < 4; k++) begin m_st[k] <= 0; m_cnt[k] <= 0; end
    end else begin
      sa1 <= a_pin; sa2 <= sa1; sb1 <= b_pin; sb2 <= sb1;
      for (int k = 0; k < 4; k++) begin
        if (!enable) begin m_st[k] <= 0; m_cnt[k] <= 0; end
        else case (m_st[k])
          0: if (!sa2[k]) m_st[k] <= 1;
             else if (line_bidir(k) && !sb2[k]) m_st[k] <= 2;
          1: if (sa2[k]) begin m_st[k] <= 3; m_cnt[k] <= int'(holdoff); end
          2: if (sb2[k]) begin m_st[k] <= 3; m_cnt[k] <= int'(holdoff); end
          default: if (m_cnt[k] == 0) m_st[k] <= 0; else m_cnt[k] <= m_cnt[k] - 1;
        endcase
      end
    end
  end

  function automatic logic [7:0] expect_pulls();
    logic [7:0] e;
    for (int k = 0; k < 4; k++) begin
      e[k]   = enable && (m_st[k] == 2);
      e[k+4] = enable && (m_st[k] == 1);
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    chk(req, {7'd0, act}, {7'd0, exp});
  endtask

  // one cycle: wait for the falling edge, compare both instances with the model
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) chk("R2/R3/R6 model", {pb, pa}, expect_pulls());
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
    chk("R1 reset", {pb, pa}, 8'd0);

    // R2: A SDA low, three edges
    ext_a[0] = 1'b1;
    tick(2); chk1("R2 not yet", pb[0], 1'b0);
    tick(1); chk1("R2 b_sda_pull", pb[0], 1'b1);
    chk1("R2 no echo a", pa[0], 1'b0);
    ext_a[0] = 1'b0; tick(12);

    // R3 + R4: B SDA low, own A low not echoed, no lockup
    ext_b[0] = 1'b1;
    tick(3); chk1("R3 a_sda_pull", pa[0], 1'b1);
    tick(8);
    chk1("R4 echo held off", pb[0], 1'b0);
    chk1("R4 a still pulled", pa[0], 1'b1);
    ext_b[0] = 1'b0;
    tick(12);
    chk("R4 no lockup", {pb[1:0], pa[1:0]}, 4'd0);

    // R5: both SCL low same cycle
    ext_a[1] = 1'b1; ext_b[1] = 1'b1;
    tick(3);
    chk1("R5 b_scl_pull", pb[1], 1'b1);
    chk1("R5 a_scl_pull", pa[1], 1'b0);
    ext_a[1] = 1'b0; ext_b[1] = 1'b0; tick(12);

    // R9: B owns SDA, external A low injected
    ext_b[0] = 1'b1; tick(4);
    ext_a[0] = 1'b1; tick(6);
    chk1("R9 b_sda_pull", pb[0], 1'b0);
    chk1("R9 a_sda_pull", pa[0], 1'b1);
    ext_a[0] = 1'b0; ext_b[0] = 1'b0; tick(12);

    // R6: hold-off window with holdoff=4
    holdoff = 4'd4;
    ext_a[0] = 1'b1; tick(4);
    ext_a[0] = 1'b0; ext_b[0] = 1'b1;
    tick(3); chk("R6 released", {pb[0], pa[0]}, 2'b00);
    tick(5); chk1("R6 still ignoring b", pa[0], 1'b0);
    tick(1); chk1("R6 b taken after idle", pa[0], 1'b1);
    ext_b[0] = 1'b0; tick(14);

    // R8: enable drop
    holdoff = 4'd3;
    ext_a[1] = 1'b1; tick(4);
    chk1("R8 before", pb[1], 1'b1);
    enable = 1'b0; #1;
    chk1("R8 released at once", pb[1], 1'b0);
    tick(3);
    chk("R8 all released", {pb, pa}, 8'd0);
    enable = 1'b1;
    tick(1); chk1("R8 restart from idle", pb[1], 1'b1);
    ext_a[1] = 1'b0; tick(12);

    // R7: one-way SCL instance ignores side B SCL
    ext_b[1] = 1'b1; tick(6);
    chk1("R7 ow a_scl_pull", pa[3], 1'b0);
    chk1("R7 bidir a_scl_pull", pa[1], 1'b1);
    ext_b[1] = 1'b0; tick(12);
    ext_a[1] = 1'b1; tick(3);
    chk1("R7 ow forwards a", pb[3], 1'b1);
    ext_a[1] = 1'b0; tick(12);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) ext_a[0] = !ext_a[0];
      if ($urandom_range(7) == 0) ext_a[1] = !ext_a[1];
      if ($urandom_range(7) == 0) ext_b[0] = !ext_b[0];
      if ($urandom_range(7) == 0) ext_b[1] = !ext_b[1];
      if ($urandom_range(63) == 0) holdoff = 4'($urandom_range(5, 2));
      enable = ($urandom_range(99) != 0);
      tick(1);
      checks++;
      if (pa[3] !== 1'b0) begin
        errors++;
        $display("FAIL R7 random: actual=%b expected=0", pa[3]);
      end
    end

    // R4: lockup-free ending
    ext_a = '0; ext_b = '0; enable = 1'b1;
    tick(16);
    chk("R4 final release", {pb, pa}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule